// File: doc/BRIEF.md
# Register-Programmed SPI Word Master

This block is a serial-peripheral master that a host programs through a small 32-bit register port. The host picks one of eight active-low slave selects, sets clock polarity and phase, bit order for each direction, word width and the serial clock rate, then writes a word to the transmit register. That write starts one full-duplex exchange of 8 or 16 bits: data goes out on MOSI while MISO is captured at a programmable point inside each bit. When the last bit has been exchanged, the received word is latched, a cause flag is set and the interrupt output goes high until the host clears it.

The serial clock rate comes from a prescale field that a small clock generator decodes into the length of each half bit period. The MISO capture point can be moved later within the half period that follows the sampling edge. This gives more margin for read data at high rates in the mode where both polarity and phase are set.

Top module: `spi_word_master`

## Requirements
- R1: After reset all select lines are high, SCLK and MOSI are low, the interrupt is low, the control, configuration and cause registers read 0, and the timing register (byte offset 0x18) reads 0x40, which is a capture delay of 1.
- R2: Control register (offset 0x00) bits [4:2] pick one of the eight select lines and bit 0 drives it low. Every other line stays high, and all lines are high while bit 0 is clear.
- R3: Configuration register (offset 0x04) bit 11 sets the idle SCLK level and bit 12 the phase. With phase 0, SCLK stays at idle for the first half bit; with phase 1 it leaves idle at the start of the word. Each word makes exactly two SCLK transitions per bit and leaves SCLK at the idle level.
- R4: Configuration bit 13 sends least significant bit first and bit 14 assembles received bits least significant first. The two settings are independent, and a cleared bit means most significant bit first.
- R5: Configuration bit 5 selects 16-bit words; when clear, words are 8 bits and bits [31:8] of the receive register (offset 0x0C) read 0.
- R6: A write to the transmit register (offset 0x08) while idle starts one word, and control bit 1 reads 1 while a word is in progress. A write to the transmit register during a word is ignored and does not start another word.
- R7: At the end of a word the cause register (offset 0x10) bit 0 and the irq output go high, and the receive register holds the word that was captured. Writing 0 to the cause register clears both, and a nonzero write leaves them set.
- R8: With configuration bits [4:0] equal to P, each SCLK half period lasts P+1 clock cycles, so a word takes 2·N·(P+1) cycles from the write to the rise of irq, N being the word width.
- R9: Timing register bits [7:6] hold a delay d. MISO is captured d clock cycles after each sampling edge, or at the last cycle of that half period if d exceeds P.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 8 | Active-low slave selects |
| irq | output | 1 | Word-complete interrupt, high until cleared |

## Verification
The assertions assume that the configuration and timing registers are only rewritten while no word is in flight. The shift engine reads polarity, phase, order, width and prescale live, so a change during a word would break the phase and edge-count properties. The bench follows this rule: it always waits for irq before it touches the configuration again. It also makes its only write during a word to the transmit register, which the ignore check exercises on purpose. MISO is driven by the bench either straight from MOSI or through a fixed six-cycle delay line, so the captured word depends only on the programmed order and the capture delay.

// File: rtl/spim_pkg.sv
package spim_pkg;

    // Register byte offsets
    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_CFG   = 'h04;
    localparam int OFS_TXD   = 'h08;
    localparam int OFS_RXD   = 'h0C;
    localparam int OFS_CAUSE = 'h10;
    localparam int OFS_TIME  = 'h18;

    // Field positions
    localparam int CTL_ON     = 0;
    localparam int CTL_BUSY   = 1;
    localparam int CTL_IDX    = 2;
    localparam int CFG_WIDE   = 5;
    localparam int CFG_CPOL   = 11;
    localparam int CFG_CPHA   = 12;
    localparam int CFG_TXLSB  = 13;
    localparam int CFG_RXLSB  = 14;
    localparam int TIM_DLY    = 6;

    localparam int PRE_W      = 5;
    localparam int MAX_BITS   = 16;
    localparam int HALF_W     = $clog2(2 * MAX_BITS);
    localparam int BIT_W      = $clog2(MAX_BITS);
    localparam logic [1:0] DLY_RESET = 2'd1;

    typedef struct packed {
        logic             rx_lsb;
        logic             tx_lsb;
        logic             cpha;
        logic             cpol;
        logic             wide;
        logic [PRE_W-1:0] prescale;
    } xfer_cfg_t;

    typedef enum logic [0:0] {ENG_IDLE = 1'b0, ENG_SHIFT = 1'b1} eng_state_t;

    // Word bit that travels as serial position k
    function automatic logic [BIT_W-1:0] stream_pos(input logic [BIT_W-1:0] k,
                                                    input logic lsb_first,
                                                    input logic wide);
        logic [BIT_W-1:0] top;
        top = wide ? BIT_W'(MAX_BITS - 1) : BIT_W'(MAX_BITS / 2 - 1);
        return lsb_first ? k : top - k;
    endfunction

endpackage

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int ADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic                busy,
    input  logic                done,
    input  logic [MAX_BITS-1:0] rx_word,
    output xfer_cfg_t           cfg,
    output logic [1:0]          dly,
    output logic                start,
    output logic [MAX_BITS-1:0] tx_word,
    output logic [NUM_CS-1:0]   cs_n,
    output logic                irq
);
    localparam int IDX_W = $clog2(NUM_CS);

    logic             sel_on;
    logic [IDX_W-1:0] sel_idx;
    logic             flag;

    logic hit_ctrl, hit_cfg, hit_txd, hit_cause, hit_time;
    assign hit_ctrl  = wr && (addr == ADDR_W'(OFS_CTRL));
    assign hit_cfg   = wr && (addr == ADDR_W'(OFS_CFG));
    assign hit_txd   = wr && (addr == ADDR_W'(OFS_TXD));
    assign hit_cause = wr && (addr == ADDR_W'(OFS_CAUSE));
    assign hit_time  = wr && (addr == ADDR_W'(OFS_TIME));

    assign start   = hit_txd && !busy;
    assign tx_word = wdata[MAX_BITS-1:0];
    assign irq     = flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_on  <= 1'b0;
            sel_idx <= '0;
            cfg     <= '0;
            dly     <= DLY_RESET;
            flag    <= 1'b0;
        end else begin
            if (hit_ctrl) begin
                sel_on  <= wdata[CTL_ON];
                sel_idx <= wdata[CTL_IDX +: IDX_W];
            end
            if (hit_cfg) begin
                cfg.prescale <= wdata[PRE_W-1:0];
                cfg.wide     <= wdata[CFG_WIDE];
                cfg.cpol     <= wdata[CFG_CPOL];
                cfg.cpha     <= wdata[CFG_CPHA];
                cfg.tx_lsb   <= wdata[CFG_TXLSB];
                cfg.rx_lsb   <= wdata[CFG_RXLSB];
            end
            if (hit_time)
                dly <= wdata[TIM_DLY +: 2];
            if (done)
                flag <= 1'b1;
            else if (hit_cause && (wdata == 32'd0))
                flag <= 1'b0;
        end
    end

    // One select line per index
    for (genvar i = 0; i < NUM_CS; i++) begin : g_sel
        assign cs_n[i] = !(sel_on && (sel_idx == IDX_W'(i)));
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_CTRL)) begin
            rdata[CTL_ON]             = sel_on;
            rdata[CTL_BUSY]           = busy;
            rdata[CTL_IDX +: IDX_W]   = sel_idx;
        end else if (addr == ADDR_W'(OFS_CFG)) begin
            rdata[PRE_W-1:0]  = cfg.prescale;
            rdata[CFG_WIDE]   = cfg.wide;
            rdata[CFG_CPOL]   = cfg.cpol;
            rdata[CFG_CPHA]   = cfg.cpha;
            rdata[CFG_TXLSB]  = cfg.tx_lsb;
            rdata[CFG_RXLSB]  = cfg.rx_lsb;
        end else if (addr == ADDR_W'(OFS_RXD)) begin
            rdata[MAX_BITS-1:0] = rx_word;
        end else if (addr == ADDR_W'(OFS_CAUSE)) begin
            rdata[0] = flag;
        end else if (addr == ADDR_W'(OFS_TIME)) begin
            rdata[TIM_DLY +: 2] = dly;
        end
    end

    a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1);
    a_r7_flag_sets: assert property (@(posedge clk) disable iff (rst)
        done |=> irq);
    a_r7_zero_clears: assert property (@(posedge clk) disable iff (rst)
        (hit_cause && (wdata == 32'd0) && !done) |=> !irq);
    a_r7_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (irq && !(hit_cause && (wdata == 32'd0))) |=> irq);

endmodule

// File: rtl/spim_clkgen.sv
module spim_clkgen
    import spim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] prescale,
    input  logic [1:0]       dly,
    output logic             half_last,
    output logic             samp_pt
);
    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] dly_x;
    logic [PRE_W-1:0] samp_at;

    assign dly_x     = PRE_W'(dly);
    assign samp_at   = (dly_x > prescale) ? prescale : dly_x;
    assign half_last = (cnt == prescale);
    assign samp_pt   = (cnt == samp_at);

    always_ff @(posedge clk) begin
        if (rst || restart || !run || half_last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= prescale));

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [MAX_BITS-1:0] tx_in,
    input  xfer_cfg_t           cfg,
    input  logic                half_last,
    input  logic                samp_pt,
    input  logic                miso,
    output logic                sclk,
    output logic                mosi,
    output logic                busy,
    output logic                done,
    output logic [MAX_BITS-1:0] rx_word
);
    eng_state_t          state;
    logic [HALF_W-1:0]   half;
    logic [MAX_BITS-1:0] tx_sh;
    logic [MAX_BITS-1:0] rx_acc;
    logic [MAX_BITS-1:0] rx_next;
    logic [HALF_W-1:0]   last_half;
    logic [BIT_W-1:0]    k;
    logic [BIT_W-1:0]    tx_idx;
    logic [BIT_W-1:0]    rx_idx;
    logic                sample;

    assign busy      = (state == ENG_SHIFT);
    assign last_half = cfg.wide ? HALF_W'(2 * MAX_BITS - 1) : HALF_W'(MAX_BITS - 1);
    assign k         = half[HALF_W-1:1];
    assign tx_idx    = stream_pos(k, cfg.tx_lsb, cfg.wide);
    assign rx_idx    = stream_pos(k, cfg.rx_lsb, cfg.wide);

    // Bit k occupies halves 2k and 2k+1; the sampling edge opens half 2k+1
    assign sclk   = busy ? (cfg.cpol ^ cfg.cpha ^ half[0]) : cfg.cpol;
    assign mosi   = busy ? tx_sh[tx_idx] : 1'b0;
    assign sample = busy && half[0] && samp_pt;
    assign done   = busy && (half == last_half) && half_last;

    always_comb begin
        rx_next = rx_acc;
        if (sample)
            rx_next[rx_idx] = miso;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ENG_IDLE;
            half    <= '0;
            tx_sh   <= '0;
            rx_acc  <= '0;
            rx_word <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        state  <= ENG_SHIFT;
                        half   <= '0;
                        tx_sh  <= tx_in;
                        rx_acc <= '0;
                    end
                end
                default: begin
                    rx_acc <= rx_next;
                    if (done) begin
                        state   <= ENG_IDLE;
                        rx_word <= rx_next;
                    end else if (half_last) begin
                        half <= half + 1'b1;
                    end
                end
            endcase
        end
    end

    a_r6_busy_until_done: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
    a_r6_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
    a_r3_last_level: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(sclk) == (cfg.cpol ^ !cfg.cpha)));

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spim_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n,
    output logic              irq
);
    xfer_cfg_t           cfg;
    logic [1:0]          dly;
    logic                start;
    logic                busy;
    logic                done;
    logic                half_last;
    logic                samp_pt;
    logic [MAX_BITS-1:0] tx_word;
    logic [MAX_BITS-1:0] rx_word;

    spim_regs #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .busy(busy), .done(done), .rx_word(rx_word),
        .cfg(cfg), .dly(dly), .start(start), .tx_word(tx_word),
        .cs_n(spi_cs_n), .irq(irq)
    );

    spim_clkgen u_clkgen (
        .clk(clk), .rst(rst), .run(busy), .restart(start),
        .prescale(cfg.prescale), .dly(dly),
        .half_last(half_last), .samp_pt(samp_pt)
    );

    spim_engine u_engine (
        .clk(clk), .rst(rst), .start(start), .tx_in(tx_word), .cfg(cfg),
        .half_last(half_last), .samp_pt(samp_pt), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .busy(busy), .done(done),
        .rx_word(rx_word)
    );

endmodule

// File: tb/tb_spi_word_master.sv
module tb_spi_word_master;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, miso, irq;
    logic [7:0]  cs_n;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    // MISO source: loopback or six-cycle delay line
    logic       dly_sel = 1'b0;
    logic [5:0] pipe = '0;
    always @(posedge clk) pipe <= {pipe[4:0], mosi};
    assign miso = dly_sel ? pipe[5] : mosi;

    // SCLK transition counter
    int   edges = 0;
    logic sclk_prev = 1'b0;
    always @(posedge clk) begin
        if (sclk !== sclk_prev) edges <= edges + 1;
        sclk_prev <= sclk;
    end

    spi_word_master dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(sclk),
        .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n), .irq(irq)
    );

    typedef struct packed {
        logic [15:0] cfg;
        logic [2:0]  cs;
        logic [15:0] tx;
        logic [15:0] rx;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'h0001, 3'd0, 16'h00A5, 16'h00A5},
        '{16'h1000, 3'd1, 16'h003C, 16'h003C},
        '{16'h0822, 3'd2, 16'h1234, 16'h1234},
        '{16'h1823, 3'd3, 16'hBEEF, 16'hBEEF},
        '{16'h6001, 3'd4, 16'h0001, 16'h0001},
        '{16'h2001, 3'd5, 16'h0001, 16'h0080},
        '{16'h4020, 3'd6, 16'h0001, 16'h8000},
        '{16'h2021, 3'd7, 16'h00F0, 16'h0F00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!irq && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_word(input vec_t v, input string tag);
        logic [31:0] r;
        int n, e0, nb, p;
        nb = v.cfg[5] ? 16 : 8;
        p  = int'(v.cfg[4:0]);
        wr(5'h04, {16'h0, v.cfg});
        wr(5'h00, {27'h0, v.cs, 2'b01});
        repeat (2) @(negedge clk);
        e0 = edges;
        wr(5'h08, {16'h0, v.tx});
        chk({tag, " R3 first-half level"}, {31'h0, sclk}, {31'h0, v.cfg[11] ^ v.cfg[12]});
        wait_irq(n);
        chk({tag, " R8 word length"}, n, 2 * nb * (p + 1));
        chk({tag, " R7 irq"}, {31'h0, irq}, 32'h1);
        rd(5'h0C, r);
        chk({tag, " R4 R5 rx word"}, r, {16'h0, v.rx});
        chk({tag, " R2 select"}, {24'h0, cs_n}, {24'h0, ~(8'h01 << v.cs)});
        repeat (3) @(negedge clk);
        chk({tag, " R3 edge count"}, edges - e0, 2 * nb);
        chk({tag, " R3 idle level"}, {31'h0, sclk}, {31'h0, v.cfg[11]});
        wr(5'h10, 32'h0);
        chk({tag, " R7 clear"}, {31'h0, irq}, 32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        int n;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 cs_n", {24'h0, cs_n}, 32'hFF);
        chk("R1 sclk", {31'h0, sclk}, 32'h0);
        chk("R1 mosi", {31'h0, mosi}, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        rd(5'h00, r); chk("R1 control", r, 32'h0);
        rd(5'h04, r); chk("R1 config", r, 32'h0);
        rd(5'h10, r); chk("R1 cause", r, 32'h0);
        rd(5'h18, r); chk("R1 timing", r, 32'h40);

        // Table of modes, orders, widths and rates
        for (int i = 0; i < NV; i++) run_word(VECS[i], $sformatf("vec%0d", i));

        // R2 select release
        wr(5'h00, 32'h1C);
        chk("R2 all released", {24'h0, cs_n}, 32'hFF);

        // R6 busy and ignored write during a word
        wr(5'h04, 32'h0001);
        wr(5'h08, 32'h55);
        rd(5'h00, r);
        chk("R6 busy bit", {31'h0, r[1]}, 32'h1);
        wr(5'h08, 32'hAA);
        wait_irq(n);
        rd(5'h0C, r);
        chk("R6 ignored write keeps word", r, 32'h55);
        rd(5'h00, r);
        chk("R6 idle after word", {31'h0, r[1]}, 32'h0);

        // R7 nonzero write keeps flag, zero write clears
        wr(5'h10, 32'h1);
        chk("R7 nonzero keeps irq", {31'h0, irq}, 32'h1);
        rd(5'h10, r);
        chk("R7 cause reads set", r, 32'h1);
        wr(5'h10, 32'h0);
        repeat (40) @(negedge clk);
        chk("R6 no second word", {31'h0, irq}, 32'h0);

        // R9 capture delay against a six-cycle delayed MISO
        dly_sel = 1'b1;
        wr(5'h04, 32'h0003);
        wr(5'h18, 32'h40);
        wr(5'h08, 32'hB3);
        wait_irq(n);
        rd(5'h0C, r); chk("R9 delay 1", r, 32'h59);
        wr(5'h10, 32'h0);
        wr(5'h18, 32'h80);
        wr(5'h08, 32'hB3);
        wait_irq(n);
        rd(5'h0C, r); chk("R9 delay 2", r, 32'hB3);
        wr(5'h10, 32'h0);
        wr(5'h18, 32'h00);
        wr(5'h08, 32'hB3);
        wait_irq(n);
        rd(5'h0C, r); chk("R9 delay 0", r, 32'h59);
        wr(5'h10, 32'h0);
        wr(5'h18, 32'hC0);
        wr(5'h08, 32'hB3);
        wait_irq(n);
        rd(5'h0C, r); chk("R9 delay 3", r, 32'hB3);
        wr(5'h10, 32'h0);
        dly_sel = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule